// File: doc/BRIEF.md
# Flash In-Application Write Controller

This block runs writes of user data into non-volatile memory while the processor keeps executing code. It accepts two kinds of request. A byte request stores one byte at an offset inside the selected page. A block request copies a 32-byte slice of the register file into one aligned 32-byte block of that page, all in a single parallel write. Both kinds share one fixed write time, set in clock cycles by a parameter. While the write runs, a stall output holds the processor.

Before any write starts, the target page is compared against a protected window. Two configuration registers bound the window: a first protected page and a first unprotected page. A request that lands inside the window is refused and flagged. An interrupt that arrives during a write abandons it before memory is touched, and an abort flag is raised. The block drives a behavioural memory port that carries a block-aligned address, 32 byte enables and 32 data bytes. The port strobes once, when a write completes.

Top module: `flash_iap_ctrl`

## Requirements
- R1: A byte request stores `byte_data` at address `page_sel*256 + byte_off`. The memory port carries the block-aligned address with `mem_be` one-hot on lane `byte_off[4:0]`, so no other byte changes.
- R2: A block request writes all 32 bytes. Byte k of `rf_data` (bits 8k+7..8k) goes to address base+k, with `mem_be` all ones.
- R3: The block base address is `page_sel*256 + (blk_idx mod 8)*32`, so only the low 3 bits of `blk_idx` count. Page 5 with index 4 covers 0x580..0x59F. Index 12 on page 2 lands on 0x280..0x29F.
- R4: An accepted request raises `busy` at the next clock edge and holds it for exactly WRITE_CYC cycles. `mem_we` pulses for one cycle, in the cycle after the last busy cycle.
- R5: If `irq` is high in a busy cycle, `busy` drops at the next edge and `st_abort` is set. No memory write happens for that request.
- R6: When `cfg_lock_pg` < `cfg_unlock_pg`, a page p with lock <= p < unlock is protected. A request to such a page is refused at the next edge: `st_prot` is set, `busy` stays low and memory is not written.
- R7: When lock == unlock, or lock > unlock, no page is protected. Both configuration registers reset to 0 and load from their inputs when `cfg_we` is high.
- R8: While `prog_mode` is high, the protected window is ignored and requests to any page are accepted.
- R9: `st_abort` and `st_prot` stay set until the next request is taken while idle, which clears both. Reset clears `busy`, `mem_we` and both status bits.
- R10: Requests that arrive while `busy` is high are ignored. If a byte request and a block request come in the same cycle, only the byte request is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load both protection bounds |
| cfg_lock_pg | input | 8 | First protected page |
| cfg_unlock_pg | input | 8 | First unprotected page after the window |
| prog_mode | input | 1 | Ignore the protected window |
| irq | input | 1 | Interrupt request; aborts a running write |
| wr_byte_req | input | 1 | Single-byte write request (one cycle) |
| wr_blk_req | input | 1 | 32-byte block write request (one cycle) |
| page_sel | input | 8 | Target page number |
| byte_off | input | 8 | Byte offset inside the page for byte requests |
| blk_idx | input | 8 | Block index for block requests; low 3 bits used |
| byte_data | input | 8 | Data byte for byte requests |
| rf_data | input | 256 | Register file locations 0..31, location k in bits 8k+7..8k |
| busy | output | 1 | Processor stall while a write runs |
| st_abort | output | 1 | Last write was abandoned by an interrupt |
| st_prot | output | 1 | Last request hit the protected window |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_addr | output | 16 | Block-aligned byte address |
| mem_be | output | 32 | Byte lane enables |
| mem_wdata | output | 256 | Lane data, lane k in bits 8k+7..8k |

## Verification
Two situations are hard to create from the ports. One is an interrupt that lands in the middle of a write. The other is a request that arrives while a write is still running. In both cases the evidence is something that does not happen: memory stays unchanged even though a valid address and data were offered. The bench reaches them by starting a write, counting a few busy cycles at the falling edge, and then pulsing `irq` or a second request. It then waits well beyond the write time and reads back the bytes that the dropped write would have touched. The window edges need care too: the lock page is protected and the unlock page is not. Each edge page is therefore aimed at directly, with no programming override, with the override, and with empty or inverted bounds.

// File: rtl/flash_iap_pkg.sv
// Shared types for the flash in-application write controller.
// Assumes the request inputs are one-cycle pulses from the processor side.
package flash_iap_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_BYTE  = 2'd1,
        OP_BLOCK = 2'd2
    } iap_op_e;

    // Decode the request pair; the byte request wins a tie.
    function automatic iap_op_e pick_op(input logic byte_req, input logic blk_req);
        if (byte_req)
            return OP_BYTE;
        else if (blk_req)
            return OP_BLOCK;
        else
            return OP_NONE;
    endfunction

endpackage

// File: rtl/iap_target.sv
// Target formation: builds the block-aligned address, the lane enables
// and the lane data for a request, and decides whether the page is guarded.
// Assumes PAGE_BYTES and BLK_BYTES are powers of two and IDX_IN_W covers
// the block index field; only the low index bits are used.
module iap_target
    import flash_iap_pkg::*;
#(
    parameter int PAGE_W     = 8,
    parameter int PAGE_BYTES = 256,
    parameter int BLK_BYTES  = 32,
    parameter int IDX_IN_W   = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int LANE_W    = $clog2(BLK_BYTES),
    localparam int BIDX_W    = OFF_W - LANE_W,
    localparam int ADDR_W    = PAGE_W + OFF_W,
    localparam int DATA_W    = BLK_BYTES * 8
) (
    input  iap_op_e             op,
    input  logic [PAGE_W-1:0]   page,
    input  logic [OFF_W-1:0]    byte_off,
    input  logic [IDX_IN_W-1:0] blk_idx,
    input  logic [7:0]          byte_data,
    input  logic [DATA_W-1:0]   rf_data,
    input  logic [PAGE_W-1:0]   lock_pg,
    input  logic [PAGE_W-1:0]   unlock_pg,
    input  logic                prog_mode,
    output logic [ADDR_W-1:0]   tgt_addr,
    output logic [BLK_BYTES-1:0] tgt_be,
    output logic [DATA_W-1:0]   tgt_data,
    output logic                tgt_prot
);

    logic [BIDX_W-1:0] blk_sel;

    // Choose the block inside the page: offset high bits or wrapped index.
    always_comb begin
        if (op == OP_BYTE)
            blk_sel = byte_off[OFF_W-1:LANE_W];
        else
            blk_sel = blk_idx[BIDX_W-1:0];
        tgt_addr = {page, blk_sel, {LANE_W{1'b0}}};
    end

    // Per-lane enable and data select.
    for (genvar g = 0; g < BLK_BYTES; g++) begin : g_lane
        assign tgt_be[g]         = (op == OP_BLOCK) ||
                                   (byte_off[LANE_W-1:0] == LANE_W'(g));
        assign tgt_data[g*8 +: 8] = (op == OP_BLOCK) ? rf_data[g*8 +: 8] : byte_data;
    end

    // Window check: empty when bounds are equal or inverted; override wins.
    always_comb begin
        tgt_prot = !prog_mode && (lock_pg < unlock_pg) &&
                   (page >= lock_pg) && (page < unlock_pg);
    end

    // R1: a byte request enables exactly one lane.
    always_comb begin
        if (op == OP_BYTE)
            a_r1_single_lane: assert ($countones(tgt_be) == 1);
    end

endmodule

// File: rtl/iap_seq.sv
// Write sequencer: accepts a request while idle, refuses guarded pages,
// stalls for WRITE_CYC cycles, then strobes the memory port once.
// An interrupt during the stall abandons the write. Status bits are sticky
// until the next accepted request. Assumes WRITE_CYC >= 1.
module iap_seq
    import flash_iap_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_BYTES = 32,
    parameter int WRITE_CYC = 16,
    localparam int DATA_W   = BLK_BYTES * 8,
    localparam int CNT_W    = $clog2(WRITE_CYC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  iap_op_e              op,
    input  logic [ADDR_W-1:0]    tgt_addr,
    input  logic [BLK_BYTES-1:0] tgt_be,
    input  logic [DATA_W-1:0]    tgt_data,
    input  logic                 tgt_prot,
    input  logic                 irq,
    output logic                 busy,
    output logic                 st_abort,
    output logic                 st_prot,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BLK_BYTES-1:0] mem_be,
    output logic [DATA_W-1:0]    mem_wdata
);

    logic [CNT_W-1:0] cnt;

    // Request acceptance, write timing, abort and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            st_abort  <= 1'b0;
            st_prot   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_be    <= '0;
            mem_wdata <= '0;
            cnt       <= '0;
        end else begin
            mem_we <= 1'b0;
            if (!busy) begin
                if (op != OP_NONE) begin
                    st_abort <= 1'b0;
                    if (tgt_prot) begin
                        st_prot <= 1'b1;
                    end else begin
                        st_prot   <= 1'b0;
                        busy      <= 1'b1;
                        cnt       <= CNT_W'(WRITE_CYC - 1);
                        mem_addr  <= tgt_addr;
                        mem_be    <= tgt_be;
                        mem_wdata <= tgt_data;
                    end
                end
            end else if (irq) begin
                busy     <= 1'b0;
                st_abort <= 1'b1;
            end else if (cnt == '0) begin
                busy   <= 1'b0;
                mem_we <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Checker: independent count of consecutive busy cycles.
    logic [CNT_W:0] busy_len;
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_len <= '0;
        else if (busy)
            busy_len <= busy_len + 1'b1;
        else
            busy_len <= '0;
    end

    // R4: the strobe follows exactly WRITE_CYC busy cycles.
    a_r4_write_time: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy_len == (CNT_W+1)'(WRITE_CYC)));

    // R5: an interrupt while busy ends the stall without a write.
    a_r5_irq_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && irq) |=> (!busy && st_abort && !mem_we));

    // R6: a guarded request never starts a write.
    a_r6_prot_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op != OP_NONE && tgt_prot) |=> (!busy && st_prot && !mem_we));

    // R9: the two status bits never describe the same request.
    a_r9_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_abort && st_prot));

    // R10: the captured target holds while the write runs.
    a_r10_hold_target: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mem_addr) && $stable(mem_wdata));

endmodule

// File: rtl/flash_iap_ctrl.sv
// Top of the flash in-application write controller: protection bound
// registers, request decode, target formation and the write sequencer.
// Assumes request inputs are single-cycle pulses and rf_data mirrors
// register file locations 0..BLK_BYTES-1.
module flash_iap_ctrl
    import flash_iap_pkg::*;
#(
    parameter int PAGE_W     = 8,
    parameter int PAGE_BYTES = 256,
    parameter int BLK_BYTES  = 32,
    parameter int IDX_IN_W   = 8,
    parameter int WRITE_CYC  = 16,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int ADDR_W    = PAGE_W + OFF_W,
    localparam int DATA_W    = BLK_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [PAGE_W-1:0]    cfg_lock_pg,
    input  logic [PAGE_W-1:0]    cfg_unlock_pg,
    input  logic                 prog_mode,
    input  logic                 irq,
    input  logic                 wr_byte_req,
    input  logic                 wr_blk_req,
    input  logic [PAGE_W-1:0]    page_sel,
    input  logic [OFF_W-1:0]     byte_off,
    input  logic [IDX_IN_W-1:0]  blk_idx,
    input  logic [7:0]           byte_data,
    input  logic [DATA_W-1:0]    rf_data,
    output logic                 busy,
    output logic                 st_abort,
    output logic                 st_prot,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BLK_BYTES-1:0] mem_be,
    output logic [DATA_W-1:0]    mem_wdata
);

    logic [PAGE_W-1:0]    lock_r;
    logic [PAGE_W-1:0]    unlock_r;
    iap_op_e              op;
    logic [ADDR_W-1:0]    tgt_addr;
    logic [BLK_BYTES-1:0] tgt_be;
    logic [DATA_W-1:0]    tgt_data;
    logic                 tgt_prot;

    // Protection bound registers, cleared to an empty window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_r   <= '0;
            unlock_r <= '0;
        end else if (cfg_we) begin
            lock_r   <= cfg_lock_pg;
            unlock_r <= cfg_unlock_pg;
        end
    end

    // Request decode with byte priority.
    always_comb op = pick_op(wr_byte_req, wr_blk_req);

    iap_target #(
        .PAGE_W     (PAGE_W),
        .PAGE_BYTES (PAGE_BYTES),
        .BLK_BYTES  (BLK_BYTES),
        .IDX_IN_W   (IDX_IN_W)
    ) u_target (
        .op        (op),
        .page      (page_sel),
        .byte_off  (byte_off),
        .blk_idx   (blk_idx),
        .byte_data (byte_data),
        .rf_data   (rf_data),
        .lock_pg   (lock_r),
        .unlock_pg (unlock_r),
        .prog_mode (prog_mode),
        .tgt_addr  (tgt_addr),
        .tgt_be    (tgt_be),
        .tgt_data  (tgt_data),
        .tgt_prot  (tgt_prot)
    );

    iap_seq #(
        .ADDR_W    (ADDR_W),
        .BLK_BYTES (BLK_BYTES),
        .WRITE_CYC (WRITE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .tgt_addr  (tgt_addr),
        .tgt_be    (tgt_be),
        .tgt_data  (tgt_data),
        .tgt_prot  (tgt_prot),
        .irq       (irq),
        .busy      (busy),
        .st_abort  (st_abort),
        .st_prot   (st_prot),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: tb/test_flash_iap_ctrl.sv
// Directed bench for flash_iap_ctrl with a behavioural byte memory.
module test_flash_iap_ctrl;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cfg_we, prog_mode, irq, wr_byte_req, wr_blk_req;
    logic [7:0]   cfg_lock_pg, cfg_unlock_pg, page_sel, byte_off, blk_idx, byte_data;
    logic [255:0] rf_data;
    logic         busy, st_abort, st_prot, mem_we;
    logic [15:0]  mem_addr;
    logic [31:0]  mem_be;
    logic [255:0] mem_wdata;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    flash_iap_ctrl #(.WRITE_CYC(W)) i_flash_iap_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lock_pg(cfg_lock_pg),
        .cfg_unlock_pg(cfg_unlock_pg), .prog_mode(prog_mode), .irq(irq),
        .wr_byte_req(wr_byte_req), .wr_blk_req(wr_blk_req), .page_sel(page_sel),
        .byte_off(byte_off), .blk_idx(blk_idx), .byte_data(byte_data),
        .rf_data(rf_data), .busy(busy), .st_abort(st_abort), .st_prot(st_prot),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata)
    );

    // Behavioural memory, 2 KiB, erased to FF on reset.
    logic [7:0] mem [0:2047];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= 8'hFF;
        end else if (mem_we) begin
            for (int k = 0; k < 32; k++)
                if (mem_be[k]) mem[11'(mem_addr[10:0] + 11'(k))] <= mem_wdata[k*8 +: 8];
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One-cycle request, ends at the falling edge after the accepting edge.
    task automatic req(input bit is_byte, input bit is_blk, input logic [7:0] pg,
                       input logic [7:0] off, input logic [7:0] idx, input logic [7:0] d);
        wr_byte_req = is_byte; wr_blk_req = is_blk;
        page_sel = pg; byte_off = off; blk_idx = idx; byte_data = d;
        @(negedge clk);
        wr_byte_req = 1'b0; wr_blk_req = 1'b0;
    endtask

    // Count busy cycles at falling edges; leaves one edge for the memory update.
    task automatic run_len(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic set_cfg(input logic [7:0] lo, input logic [7:0] hi);
        cfg_we = 1'b1; cfg_lock_pg = lo; cfg_unlock_pg = hi;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        int n;
        chk("R9 reset busy", 32'(busy), 0);
        chk("R9 reset st_abort", 32'(st_abort), 0);
        chk("R9 reset st_prot", 32'(st_prot), 0);
        chk("R9 reset mem_we", 32'(mem_we), 0);
        req(1, 0, 8'd0, 8'h00, 8'd0, 8'h11);
        chk("R7 reset bounds leave page 0 open", 32'(busy), 1);
        run_len(n);
        @(negedge clk);
        chk("R7 page 0 written", 32'(mem[0]), 32'h11);
    endtask

    task automatic t_byte();
        int n;
        req(1, 0, 8'd3, 8'h47, 8'd0, 8'hA5);
        chk("R4 busy after accept", 32'(busy), 1);
        run_len(n);
        chk("R4 busy length", 32'(n), W);
        chk("R4 strobe after busy", 32'(mem_we), 1);
        chk("R1 lane one-hot", mem_be, 32'h0000_0080);
        chk("R1 aligned addr", 32'(mem_addr), 32'h340);
        @(negedge clk);
        chk("R4 strobe one cycle", 32'(mem_we), 0);
        chk("R1 byte stored", 32'(mem[11'h347]), 32'hA5);
        chk("R1 lower neighbour", 32'(mem[11'h346]), 32'hFF);
        chk("R1 upper neighbour", 32'(mem[11'h348]), 32'hFF);
    endtask

    task automatic t_block(input logic [7:0] pg, input logic [7:0] idx,
                           input logic [10:0] base, input logic [7:0] seed, input string tag);
        int n;
        int bad = 0;
        for (int k = 0; k < 32; k++) rf_data[k*8 +: 8] = seed + 8'(k);
        req(0, 1, pg, 8'h00, idx, 8'h00);
        run_len(n);
        chk({tag, " all lanes"}, mem_be, 32'hFFFF_FFFF);
        @(negedge clk);
        for (int k = 0; k < 32; k++)
            if (mem[11'(base + 11'(k))] !== seed + 8'(k)) bad++;
        chk({tag, " block bytes"}, 32'(bad), 0);
        chk({tag, " byte below block"}, 32'(mem[11'(base - 11'd1)]), 32'hFF);
        chk({tag, " byte above block"}, 32'(mem[11'(base + 11'd32)]), 32'hFF);
    endtask

    task automatic t_abort();
        int n;
        req(1, 0, 8'd1, 8'h10, 8'd0, 8'h3C);
        repeat (3) @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        chk("R5 busy dropped", 32'(busy), 0);
        chk("R5 abort flag", 32'(st_abort), 1);
        repeat (W + 3) @(negedge clk);
        chk("R5 no memory write", 32'(mem[11'h110]), 32'hFF);
        chk("R9 abort sticky", 32'(st_abort), 1);
        req(1, 0, 8'd1, 8'h11, 8'd0, 8'h5A);
        chk("R9 abort cleared by new request", 32'(st_abort), 0);
        run_len(n);
        @(negedge clk);
        chk("R5 later write works", 32'(mem[11'h111]), 32'h5A);
    endtask

    task automatic t_prot();
        int n;
        set_cfg(8'd2, 8'd4);
        req(1, 0, 8'd3, 8'h20, 8'd0, 8'h77);
        chk("R6 refused no busy", 32'(busy), 0);
        chk("R6 prot flag", 32'(st_prot), 1);
        repeat (W + 3) @(negedge clk);
        chk("R6 memory untouched", 32'(mem[11'h320]), 32'hFF);
        req(1, 0, 8'd2, 8'h20, 8'd0, 8'h78);
        chk("R6 lock page guarded", 32'(st_prot) << 1 | 32'(busy), 2);
        req(1, 0, 8'd4, 8'h20, 8'd0, 8'h79);
        chk("R6 unlock page open", 32'(busy), 1);
        chk("R9 prot cleared by new request", 32'(st_prot), 0);
        run_len(n);
        @(negedge clk);
        chk("R6 unlock page written", 32'(mem[11'h420]), 32'h79);
        prog_mode = 1'b1;
        req(1, 0, 8'd3, 8'h21, 8'd0, 8'h7A);
        chk("R8 override accepts", 32'(busy), 1);
        run_len(n);
        @(negedge clk);
        prog_mode = 1'b0;
        chk("R8 guarded page written", 32'(mem[11'h321]), 32'h7A);
    endtask

    task automatic t_empty();
        int n;
        set_cfg(8'd3, 8'd3);
        req(1, 0, 8'd3, 8'h30, 8'd0, 8'h81);
        chk("R7 equal bounds open", 32'(busy), 1);
        run_len(n);
        @(negedge clk);
        chk("R7 equal bounds written", 32'(mem[11'h330]), 32'h81);
        set_cfg(8'd5, 8'd2);
        req(1, 0, 8'd3, 8'h31, 8'd0, 8'h82);
        chk("R7 inverted bounds open", 32'(busy), 1);
        run_len(n);
        @(negedge clk);
        chk("R7 inverted bounds written", 32'(mem[11'h331]), 32'h82);
        set_cfg(8'd0, 8'd0);
    endtask

    task automatic t_ignore();
        int n;
        req(1, 0, 8'd7, 8'h40, 8'd0, 8'h91);
        repeat (2) @(negedge clk);
        req(1, 0, 8'd7, 8'h50, 8'd0, 8'h92);
        run_len(n);
        @(negedge clk);
        chk("R10 first write landed", 32'(mem[11'h740]), 32'h91);
        repeat (W + 3) @(negedge clk);
        chk("R10 busy-time request dropped", 32'(mem[11'h750]), 32'hFF);
        for (int k = 0; k < 32; k++) rf_data[k*8 +: 8] = 8'hC0;
        req(1, 1, 8'd6, 8'h05, 8'd1, 8'h93);
        run_len(n);
        @(negedge clk);
        chk("R10 byte wins tie", 32'(mem[11'h605]), 32'h93);
        chk("R10 block loses tie", 32'(mem[11'h620]), 32'hFF);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 0; cfg_lock_pg = 0; cfg_unlock_pg = 0;
        prog_mode = 0; irq = 0; wr_byte_req = 0; wr_blk_req = 0;
        page_sel = 0; byte_off = 0; blk_idx = 0; byte_data = 0; rf_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte();
        t_block(8'd5, 8'd4, 11'h580, 8'h10, "R2 R3 page5 block4");
        t_block(8'd2, 8'd12, 11'h280, 8'h60, "R3 index wrap");
        t_abort();
        t_prot();
        t_empty();
        t_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule